// File: doc/BRIEF.md
# DDR3 Power-Up and Calibration Sequencer

This block brings a DDR3 memory subsystem from system reset to a state where normal accesses are allowed. It holds the memory reset pin low while the CPU is in reset and for a minimum time afterwards. It keeps CKE low from the start of reset. It opens the memory clock and controller enable only after a second minimum wait and once software has flagged the controller as started.

After enabling, the block waits for the clocks to settle, raises CKE and requests four mode-register writes in a fixed order. It then requests a long ZQ calibration and allows it a fixed number of cycles, which also covers DLL lock. After that it hands control in turn to an external write-leveling engine and an external read-adjust engine. Each engine is started with a one-cycle strobe and answers with a done or error pulse.

All microsecond delays are converted to cycles from a clock-frequency parameter, and a divisor shortens them for simulation. Each calibration phase is guarded by a timeout. A reported error or a timeout sets a sticky calibration-error flag.

Top module: `ddr3_pwrup_seq`

## Requirements
- R1: While `cpu_rst` is high, `mem_rst_n` is 0. After `cpu_rst` falls, `mem_rst_n` rises on exactly the HOLD_CYC-th rising edge at which `cpu_rst` is sampled low, and never on the first such edge. HOLD_CYC = RST_HOLD_US*CLK_MHZ/SIM_DIV, with a minimum of 2.
- R2: `cke` is 0 during reset and is never 1 while `mem_rst_n` is 0 or `ck_en` is 0.
- R3: `ctrl_en` and `ck_en` rise together, on the first edge at which both conditions hold: `ctrl_start` is sampled high, and at least EN_CYC = EN_WAIT_US*CLK_MHZ/SIM_DIV edges have passed since `mem_rst_n` rose.
- R4: `cke` rises STAB_CYC edges after `ck_en` rises.
- R5: Exactly four one-cycle `mrs_req` pulses follow, with `mrs_sel` carrying the mode-register number in binary in the order 2, 3, 1, 0. The first pulse comes one edge after `cke` rises, and the pulses are MR_GAP edges apart.
- R6: A one-cycle `zq_req` pulse comes MR_GAP edges after the last `mrs_req`. A one-cycle `wl_start` pulse comes ZQ_CYC edges after `zq_req`.
- R7: If `wl_done` is sampled at edge k, `ra_start` pulses at edge k+1. If `ra_done` is sampled at edge k, `init_done` rises and `init_busy` falls at edge k.
- R8: An error pulse from the active phase sets `cal_err` on the edge at which it is sampled. The phase still counts as finished, so the sequence continues and `init_done` can still rise. `cal_err` then stays 1 until `cpu_rst`.
- R9: If a phase sees neither done nor error within CAL_TMO edges of its start strobe, `cal_err` rises CAL_TMO edges after the strobe. After that, `init_busy` stays 1, `init_done` stays 0 and no further strobes are issued.
- R10: When `cpu_rst` is sampled high at any point in the sequence, the next edge returns `mem_rst_n`, `cke`, `ck_en`, `ctrl_en`, `cal_err` and `init_done` to 0 and `init_busy` to 1.
- R11: Done and error pulses that arrive outside their own phase have no effect on timing, on `cal_err` or on any output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Controller clock |
| cpu_rst | input | 1 | CPU reset, synchronous, active high |
| ctrl_start | input | 1 | Software flag that the controller may start |
| wl_done | input | 1 | Write-leveling engine finished (pulse) |
| wl_err | input | 1 | Write-leveling engine failed (pulse) |
| ra_done | input | 1 | Read-adjust engine finished (pulse) |
| ra_err | input | 1 | Read-adjust engine failed (pulse) |
| mem_rst_n | output | 1 | Memory reset pin, active low |
| cke | output | 1 | Memory clock enable |
| ck_en | output | 1 | Memory clock output gate |
| ctrl_en | output | 1 | Controller and chip-select enable |
| mrs_req | output | 1 | Mode-register write request (pulse) |
| mrs_sel | output | 2 | Mode-register number for `mrs_req` |
| zq_req | output | 1 | Long ZQ calibration request (pulse) |
| wl_start | output | 1 | Write-leveling start strobe |
| ra_start | output | 1 | Read-adjust start strobe |
| init_busy | output | 1 | Initialization in progress |
| init_done | output | 1 | Initialization complete |
| cal_err | output | 1 | Sticky calibration error |

## Verification
Every state transition of the sequencer produces a visible edge on an output, so a wrong state or a mis-counted delay appears as an event at the wrong cycle or in the wrong order. The bench therefore checks each output edge against the expected cycle offset from the previous edge. A counter that is off by one shifts the next strobe by exactly one cycle. A wrong mode-register index shows on `mrs_sel` at the pulse where it occurs. A phase that accepts stray pulses or mishandles an error shows as an unexpected `cal_err` or strobe within one cycle.

// File: rtl/ddr3_pwrup_pkg.sv
package ddr3_pwrup_pkg;

  // Order of the encodings matters: enables are derived by comparison.
  typedef enum logic [3:0] {
    ST_HOLD = 4'd0,
    ST_ENW  = 4'd1,
    ST_CLK  = 4'd2,
    ST_MRS  = 4'd3,
    ST_ZQ   = 4'd4,
    ST_WL   = 4'd5,
    ST_RA   = 4'd6,
    ST_DONE = 4'd7,
    ST_FAIL = 4'd8
  } pw_state_e;

  localparam int NUM_PHASES = 2;

  // Mode-register write order: 2, 3, 1, 0
  function automatic logic [1:0] mr_code(input logic [1:0] idx);
    case (idx)
      2'd0:    mr_code = 2'd2;
      2'd1:    mr_code = 2'd3;
      2'd2:    mr_code = 2'd1;
      default: mr_code = 2'd0;
    endcase
  endfunction

endpackage

// File: rtl/pwrup_tick.sv
module pwrup_tick #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr,
  output logic [W-1:0] cnt
);

  always_ff @(posedge clk) begin
    if (rst || clr)
      cnt <= '0;
    else if (cnt != {W{1'b1}})
      cnt <= cnt + 1'b1;
  end

endmodule

// File: rtl/pwrup_phase_eval.sv
module pwrup_phase_eval #(
  parameter int W   = 16,
  parameter int TMO = 4096
) (
  input  logic         active,
  input  logic         done,
  input  logic         err,
  input  logic [W-1:0] cnt,
  output logic         fin,
  output logic         err_hit,
  output logic         tmo
);

  localparam logic [W-1:0] TMO_V = W'(TMO);

  // An answer on the last allowed edge still beats the timeout.
  always_comb begin
    fin     = active && (done || err);
    err_hit = active && err;
    tmo     = active && !(done || err) && (cnt == TMO_V);
  end

endmodule

// File: rtl/ddr3_pwrup_seq.sv
module ddr3_pwrup_seq
  import ddr3_pwrup_pkg::*;
#(
  parameter int CLK_MHZ     = 50,
  parameter int SIM_DIV     = 1,
  parameter int RST_HOLD_US = 200,
  parameter int EN_WAIT_US  = 500,
  parameter int STAB_CYC    = 16,
  parameter int MR_GAP      = 4,
  parameter int ZQ_CYC      = 512,
  parameter int CAL_TMO     = 4096
) (
  input  logic       clk,
  input  logic       cpu_rst,
  input  logic       ctrl_start,
  input  logic       wl_done,
  input  logic       wl_err,
  input  logic       ra_done,
  input  logic       ra_err,
  output logic       mem_rst_n,
  output logic       cke,
  output logic       ck_en,
  output logic       ctrl_en,
  output logic       mrs_req,
  output logic [1:0] mrs_sel,
  output logic       zq_req,
  output logic       wl_start,
  output logic       ra_start,
  output logic       init_busy,
  output logic       init_done,
  output logic       cal_err
);

  localparam int HOLD_RAW = RST_HOLD_US * CLK_MHZ / SIM_DIV;
  localparam int EN_RAW   = EN_WAIT_US * CLK_MHZ / SIM_DIV;
  localparam int HOLD_CYC = (HOLD_RAW < 2) ? 2 : HOLD_RAW;
  localparam int EN_CYC   = (EN_RAW < 1) ? 1 : EN_RAW;
  localparam int STAB     = (STAB_CYC < 1) ? 1 : STAB_CYC;
  localparam int GAP      = (MR_GAP < 2) ? 2 : MR_GAP;
  localparam int ZQ       = (ZQ_CYC < 2) ? 2 : ZQ_CYC;
  localparam int TMO      = (CAL_TMO < 2) ? 2 : CAL_TMO;
  localparam int M1       = (HOLD_CYC > EN_CYC) ? HOLD_CYC : EN_CYC;
  localparam int M2       = (ZQ > TMO) ? ZQ : TMO;
  localparam int M3       = (M1 > M2) ? M1 : M2;
  localparam int MAXC     = (M3 > STAB) ? ((M3 > GAP) ? M3 : GAP) : STAB;
  localparam int CW       = $clog2(MAXC + 2) + 1;

  localparam logic [CW-1:0] HOLD_LAST = CW'(HOLD_CYC - 1);
  localparam logic [CW-1:0] EN_LAST   = CW'(EN_CYC - 1);
  localparam logic [CW-1:0] STAB_LAST = CW'(STAB - 1);
  localparam logic [CW-1:0] GAP_LAST  = CW'(GAP - 1);
  localparam logic [CW-1:0] ZQ_LAST   = CW'(ZQ - 1);

  pw_state_e       st, st_nx;
  logic [CW-1:0]   cnt;
  logic            cnt_clr;
  logic [1:0]      mr_idx;

  logic [NUM_PHASES-1:0] ph_act, ph_done, ph_err, ph_fin, ph_errhit, ph_tmo;

  assign ph_act  = {st == ST_RA, st == ST_WL};
  assign ph_done = {ra_done, wl_done};
  assign ph_err  = {ra_err, wl_err};

  pwrup_tick #(.W(CW)) u_tick (
    .clk (clk),
    .rst (cpu_rst),
    .clr (cnt_clr),
    .cnt (cnt)
  );

  for (genvar g = 0; g < NUM_PHASES; g++) begin : g_phase
    pwrup_phase_eval #(.W(CW), .TMO(TMO)) u_eval (
      .active  (ph_act[g]),
      .done    (ph_done[g]),
      .err     (ph_err[g]),
      .cnt     (cnt),
      .fin     (ph_fin[g]),
      .err_hit (ph_errhit[g]),
      .tmo     (ph_tmo[g])
    );
  end

  always_comb begin
    st_nx   = st;
    cnt_clr = 1'b0;
    case (st)
      ST_HOLD: if (cnt == HOLD_LAST) begin st_nx = ST_ENW; cnt_clr = 1'b1; end
      ST_ENW:  if (cnt >= EN_LAST && ctrl_start) begin st_nx = ST_CLK; cnt_clr = 1'b1; end
      ST_CLK:  if (cnt == STAB_LAST) begin st_nx = ST_MRS; cnt_clr = 1'b1; end
      ST_MRS:  if (cnt == GAP_LAST) begin
                 cnt_clr = 1'b1;
                 if (mr_idx == 2'd3) st_nx = ST_ZQ;
               end
      ST_ZQ:   if (cnt == ZQ_LAST) begin st_nx = ST_WL; cnt_clr = 1'b1; end
      ST_WL:   if (ph_fin[0]) begin st_nx = ST_RA; cnt_clr = 1'b1; end
               else if (ph_tmo[0]) st_nx = ST_FAIL;
      ST_RA:   if (ph_fin[1]) st_nx = ST_DONE;
               else if (ph_tmo[1]) st_nx = ST_FAIL;
      default: st_nx = st;
    endcase
  end

  always_ff @(posedge clk) begin
    if (cpu_rst) begin
      st        <= ST_HOLD;
      mr_idx    <= 2'd0;
      mem_rst_n <= 1'b0;
      cke       <= 1'b0;
      ck_en     <= 1'b0;
      ctrl_en   <= 1'b0;
      mrs_req   <= 1'b0;
      mrs_sel   <= 2'd0;
      zq_req    <= 1'b0;
      wl_start  <= 1'b0;
      ra_start  <= 1'b0;
      init_busy <= 1'b1;
      init_done <= 1'b0;
      cal_err   <= 1'b0;
    end else begin
      st        <= st_nx;
      if (st == ST_MRS && cnt == GAP_LAST)
        mr_idx <= mr_idx + 2'd1;
      mem_rst_n <= (st_nx != ST_HOLD);
      ctrl_en   <= (st_nx >= ST_CLK);
      ck_en     <= (st_nx >= ST_CLK);
      cke       <= (st_nx >= ST_MRS);
      mrs_req   <= (st == ST_MRS) && (cnt == '0);
      mrs_sel   <= mr_code(mr_idx);
      zq_req    <= (st == ST_ZQ) && (cnt == '0);
      wl_start  <= (st == ST_WL) && (cnt == '0);
      ra_start  <= (st == ST_RA) && (cnt == '0);
      init_busy <= (st_nx != ST_DONE);
      init_done <= (st_nx == ST_DONE);
      cal_err   <= cal_err || (|ph_errhit) || (|ph_tmo);
    end
  end

endmodule

// File: rtl/ddr3_pwrup_chk.sv
module ddr3_pwrup_chk #(
  parameter int EN_CYC = 25000
) (
  input logic clk,
  input logic cpu_rst,
  input logic mem_rst_n,
  input logic cke,
  input logic ck_en,
  input logic ctrl_en,
  input logic mrs_req,
  input logic zq_req,
  input logic wl_start,
  input logic ra_start,
  input logic init_busy,
  input logic init_done,
  input logic cal_err
);

  localparam int GW = $clog2(EN_CYC + 1) + 1;
  localparam logic [GW-1:0] EN_V = GW'(EN_CYC);

  logic [GW-1:0] gap;

  always_ff @(posedge clk) begin
    if (cpu_rst || !mem_rst_n)
      gap <= '0;
    else if (gap < EN_V)
      gap <= gap + 1'b1;
  end

  assert_rst_hold_R1: assert property (@(posedge clk) disable iff (cpu_rst)
    $past(cpu_rst) |-> !mem_rst_n);

  assert_cke_gate_R2: assert property (@(posedge clk) disable iff (cpu_rst)
    cke |-> (mem_rst_n && ck_en));

  assert_en_wait_R3: assert property (@(posedge clk) disable iff (cpu_rst)
    $rose(ctrl_en) |-> (gap >= EN_V) && ck_en);

  assert_one_strobe_R5: assert property (@(posedge clk) disable iff (cpu_rst)
    $onehot0({mrs_req, zq_req, wl_start, ra_start}));

  assert_done_state_R7: assert property (@(posedge clk) disable iff (cpu_rst)
    init_done |-> (!init_busy && cke && ctrl_en));

  assert_err_sticky_R8: assert property (@(posedge clk) disable iff (cpu_rst)
    cal_err |=> cal_err);

  assert_done_sticky_R9: assert property (@(posedge clk) disable iff (cpu_rst)
    init_done |=> init_done);

endmodule

bind ddr3_pwrup_seq ddr3_pwrup_chk #(.EN_CYC(EN_CYC)) u_pwrup_chk (
  .clk       (clk),
  .cpu_rst   (cpu_rst),
  .mem_rst_n (mem_rst_n),
  .cke       (cke),
  .ck_en     (ck_en),
  .ctrl_en   (ctrl_en),
  .mrs_req   (mrs_req),
  .zq_req    (zq_req),
  .wl_start  (wl_start),
  .ra_start  (ra_start),
  .init_busy (init_busy),
  .init_done (init_done),
  .cal_err   (cal_err)
);

// File: tb/test_ddr3_pwrup_seq.sv
module test_ddr3_pwrup_seq;

  localparam int CLK_MHZ = 50;
  localparam int SIM_DIV = 50;
  localparam int H       = 200 * CLK_MHZ / SIM_DIV;
  localparam int EN      = 500 * CLK_MHZ / SIM_DIV;
  localparam int STAB    = 16;
  localparam int G       = 4;
  localparam int ZQ      = 512;
  localparam int TMO     = 300;

  localparam int EV_RST = 0, EV_EN = 1, EV_CKE = 2, EV_MRS = 3, EV_ZQ = 4,
                 EV_WL = 5, EV_RA = 6, EV_ERR = 7, EV_DONE = 8;

  typedef struct packed { int code; int val; int dlt; } ev_s;

  logic clk = 1'b0;
  logic cpu_rst = 1'b1;
  logic ctrl_start = 1'b0;
  logic wl_done = 1'b0, wl_err = 1'b0, ra_done = 1'b0, ra_err = 1'b0;
  logic mem_rst_n, cke, ck_en, ctrl_en, mrs_req, zq_req, wl_start, ra_start;
  logic init_busy, init_done, cal_err;
  logic [1:0] mrs_sel;

  int checks = 0, fails = 0, cyc = 0, last = 0;
  bit finished = 0;
  ev_s expq[$];

  always #10 clk = ~clk;   // 50 MHz
  always @(posedge clk) cyc++;

  ddr3_pwrup_seq #(
    .CLK_MHZ(CLK_MHZ), .SIM_DIV(SIM_DIV), .RST_HOLD_US(200), .EN_WAIT_US(500),
    .STAB_CYC(STAB), .MR_GAP(G), .ZQ_CYC(ZQ), .CAL_TMO(TMO)
  ) i_ddr3_pwrup_seq (
    .clk(clk), .cpu_rst(cpu_rst), .ctrl_start(ctrl_start),
    .wl_done(wl_done), .wl_err(wl_err), .ra_done(ra_done), .ra_err(ra_err),
    .mem_rst_n(mem_rst_n), .cke(cke), .ck_en(ck_en), .ctrl_en(ctrl_en),
    .mrs_req(mrs_req), .mrs_sel(mrs_sel), .zq_req(zq_req),
    .wl_start(wl_start), .ra_start(ra_start), .init_busy(init_busy),
    .init_done(init_done), .cal_err(cal_err)
  );

  function automatic string req_of(input int code);
    case (code)
      EV_RST:  return "R1";
      EV_EN:   return "R3";
      EV_CKE:  return "R4";
      EV_MRS:  return "R5";
      EV_ZQ, EV_WL: return "R6";
      EV_RA:   return "R7";
      EV_ERR:  return "R8/R9";
      default: return "R7";
    endcase
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic push(input int code, input int val, input int dlt);
    ev_s e;
    e.code = code; e.val = val; e.dlt = dlt;
    expq.push_back(e);
  endtask

  // Monitor: pops expected events and compares code, value and spacing
  task automatic seen(input int code, input int val, input bit extra_ok);
    ev_s e;
    int d;
    d = cyc - last;
    last = cyc;
    if (expq.size() == 0) begin
      check(0, req_of(code), "unexpected event code", code, -1);
      return;
    end
    e = expq.pop_front();
    check(e.code == code, req_of(e.code), "event order code", code, e.code);
    check(e.dlt == d, req_of(e.code), "event spacing", d, e.dlt);
    if (code == EV_MRS)
      check(val == e.val, "R5", "mrs_sel", val, e.val);
    check(extra_ok, req_of(code), "companion outputs", 0, 1);
  endtask

  logic p_rst = 0, p_en = 0, p_cke = 0, p_mrs = 0, p_zq = 0, p_wl = 0,
        p_ra = 0, p_err = 0, p_done = 0;

  always @(negedge clk) begin
    if (mem_rst_n === 1'b1 && !p_rst) seen(EV_RST, 0, 1'b1);
    if (ctrl_en === 1'b1 && !p_en)    seen(EV_EN, 0, ck_en === 1'b1);
    if (cke === 1'b1 && !p_cke)       seen(EV_CKE, 0, 1'b1);
    if (mrs_req === 1'b1 && !p_mrs)   seen(EV_MRS, int'(mrs_sel), 1'b1);
    if (zq_req === 1'b1 && !p_zq)     seen(EV_ZQ, 0, 1'b1);
    if (wl_start === 1'b1 && !p_wl)   seen(EV_WL, 0, 1'b1);
    if (ra_start === 1'b1 && !p_ra)   seen(EV_RA, 0, 1'b1);
    if (cal_err === 1'b1 && !p_err)   seen(EV_ERR, 0, 1'b1);
    if (init_done === 1'b1 && !p_done) seen(EV_DONE, 0, init_busy === 1'b0);
    p_rst = (mem_rst_n === 1'b1); p_en = (ctrl_en === 1'b1); p_cke = (cke === 1'b1);
    p_mrs = (mrs_req === 1'b1); p_zq = (zq_req === 1'b1); p_wl = (wl_start === 1'b1);
    p_ra = (ra_start === 1'b1); p_err = (cal_err === 1'b1); p_done = (init_done === 1'b1);
  end

  task automatic check_reset_state(input string tag);
    check(mem_rst_n == 1'b0, "R1", {tag, " mem_rst_n"}, int'(mem_rst_n), 0);
    check(cke == 1'b0, "R2", {tag, " cke"}, int'(cke), 0);
    check(ctrl_en == 1'b0 && ck_en == 1'b0, "R10", {tag, " enables"},
          int'({ctrl_en, ck_en}), 0);
    check(cal_err == 1'b0, "R10", {tag, " cal_err"}, int'(cal_err), 0);
    check(init_busy == 1'b1 && init_done == 1'b0, "R10", {tag, " busy/done"},
          int'({init_busy, init_done}), 2);
  endtask

  task automatic run(input bit late, input int dw, input bit werr, input int dr,
                     input bit rhang, input bit stray, input bit abort);
    cpu_rst = 1'b1;
    ctrl_start = 1'b0;
    repeat (5) @(negedge clk);
    check_reset_state("reset");
    // Driver: expected event list for this run
    push(EV_RST, 0, H);
    push(EV_EN, 0, late ? EN + 21 : EN);
    push(EV_CKE, 0, STAB);
    push(EV_MRS, 2, 1);
    push(EV_MRS, 3, G);
    if (!abort) begin
      push(EV_MRS, 1, G);
      push(EV_MRS, 0, G);
      push(EV_ZQ, 0, G);
      push(EV_WL, 0, ZQ);
      if (werr) begin push(EV_ERR, 0, dw + 1); push(EV_RA, 0, 1); end
      else push(EV_RA, 0, dw + 2);
      if (rhang) push(EV_ERR, 0, TMO);
      else push(EV_DONE, 0, dr + 1);
    end
    cpu_rst = 1'b0;
    last = cyc;
    if (!late) ctrl_start = 1'b1;
    else begin
      repeat (H + EN + 20) @(negedge clk);
      ctrl_start = 1'b1;
    end
    if (abort) begin
      while (expq.size() != 0) @(negedge clk);
      cpu_rst = 1'b1;
      @(negedge clk);
      check_reset_state("abort R10");
      check(mrs_req == 1'b0, "R10", "abort mrs_req", int'(mrs_req), 0);
      return;
    end
    while (!zq_req) @(negedge clk);
    if (stray) begin  // R11: pulses outside their phases
      repeat (10) @(negedge clk);
      wl_done = 1'b1; wl_err = 1'b1; ra_done = 1'b1; ra_err = 1'b1;
      @(negedge clk);
      wl_done = 1'b0; wl_err = 1'b0; ra_done = 1'b0; ra_err = 1'b0;
      check(cal_err == 1'b0, "R11", "cal_err after stray pulses", int'(cal_err), 0);
    end
    while (!wl_start) @(negedge clk);
    repeat (dw) @(negedge clk);
    if (werr) wl_err = 1'b1; else wl_done = 1'b1;
    @(negedge clk);
    wl_done = 1'b0; wl_err = 1'b0;
    while (!ra_start) @(negedge clk);
    if (!rhang) begin
      repeat (dr) @(negedge clk);
      ra_done = 1'b1;
      @(negedge clk);
      ra_done = 1'b0;
    end
    while (expq.size() != 0) @(negedge clk);
    if (rhang) begin
      repeat (40) @(negedge clk);
      check(init_busy == 1'b1 && init_done == 1'b0, "R9", "hung busy/done",
            int'({init_busy, init_done}), 2);
    end else begin
      repeat (3) @(negedge clk);
      check(init_done == 1'b1 && init_busy == 1'b0, "R7", "final busy/done",
            int'({init_busy, init_done}), 1);
      check(cal_err == werr, "R8", "final cal_err", int'(cal_err), int'(werr));
    end
    check(expq.size() == 0, "R5", "events left", expq.size(), 0);
  endtask

  initial begin
    run(0, 3, 0, 5, 0, 1, 0);  // normal path plus stray pulses (R11)
    run(1, 2, 1, 0, 0, 0, 0);  // late start, write-level error (R3, R8)
    run(0, 0, 0, 0, 1, 0, 0);  // read-adjust timeout (R9)
    run(0, 0, 0, 0, 0, 0, 1);  // reset during mode-register writes (R10)
    finished = 1;
    $display("[TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end

  always @(posedge clk) begin
    if (!finished && cyc > 150000) begin
      finished = 1;
      checks++;
      fails++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
      $display("[TB] %0d tests run, %0d failed", checks, fails);
      $finish;
    end
  end

endmodule